// File: doc/BRIEF.md
# Reservation Monitor for Load-Linked / Store-Conditional

This block holds a single address reservation for one processor so that a load-linked access followed by a store-conditional access behaves as one atomic read-modify-write on shared memory. A load-linked request records the block that holds its target address and marks the reservation live. A later store-conditional request is judged against that reservation in the same cycle. It returns a one-word result of 1 on success or 0 on failure, and it drives the memory write strobe only when it succeeds.

The reservation is dropped by three kinds of event. An exception, interrupt or context switch on the `exc_event` input drops it. An invalidation or remote store seen on the snoop port drops it when it touches the reserved block. The reservation is also dropped once the store-conditional has been judged. Addresses are compared at block granularity, so any byte offset within the reserved block matches. Software builds atomic exchange, fetch-and-increment and spin locks by retrying the pair until the result word reads 1.

Top module: `resv_monitor`

## Requirements
- R1: A load-linked request (`req_valid`=1, `req_sc`=0) with no exception and no same-block snoop in that cycle leaves a live reservation for its block, so that a following store-conditional to that block succeeds.
- R2: A store-conditional (`req_valid`=1, `req_sc`=1) succeeds only when a reservation is live and its address lies in the reserved block. Blocks are `BLK_BYTES` bytes (default 16), so the low log2(`BLK_BYTES`) address bits are ignored and an address in any other block fails.
- R3: In the same cycle as a store-conditional request, `rsp_valid` is 1 and `rsp_result` is 1 on success or 0 on failure. `rsp_valid` is 0 in every other cycle.
- R4: `mem_we` is 1 only in the cycle of a successful store-conditional, with `mem_addr` and `mem_wdata` equal to that request's address and data. A failed store-conditional and a load-linked request issue no write.
- R5: An `exc_event` pulse clears the reservation. An exception in the same cycle as a store-conditional makes it fail, and one in the same cycle as a load-linked request prevents that reservation from being set.
- R6: A snoop (`snoop_valid`=1) whose address lies in the reserved block clears the reservation, so the next store-conditional fails.
- R7: A snoop to a block other than the reserved one has no effect on the reservation.
- R8: Every store-conditional clears the reservation whether it succeeds or fails, so that a second store-conditional to the same block fails.
- R9: A new load-linked request replaces any live reservation, so that only the newest block can succeed.
- R10: A snoop that hits the reserved block in the same cycle as a store-conditional to that block makes the store-conditional fail and write nothing.
- R11: After reset no reservation exists, and the outputs `rsp_valid` and `mem_we` are 0.
- R12: A snoop to the block of a load-linked request in the same cycle as that request leaves no reservation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| req_valid | input | 1 | Processor request present this cycle |
| req_sc | input | 1 | Request kind: 0 = load-linked, 1 = store-conditional |
| req_addr | input | AW | Request byte address |
| req_wdata | input | DW | Store-conditional data |
| snoop_valid | input | 1 | Invalidation or remote store observed this cycle |
| snoop_addr | input | AW | Byte address of the snooped access |
| exc_event | input | 1 | Exception, interrupt or context switch pulse |
| rsp_valid | output | 1 | Store-conditional result present |
| rsp_result | output | DW | 1 on success, 0 on failure |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |

## Verification
The hardest situations to reach are the same-cycle collisions. These are a snoop that lands on the reserved block exactly as the store-conditional is presented, an exception in the very cycle of a load-linked or store-conditional, and a snoop aimed at the block that a load-linked request is installing. The driver task places every input of one cycle at once, so the stimulus lines these events up deliberately instead of waiting for them to occur by chance. The bench's own reservation model then predicts the result word and the write strobe for each collision.

// File: rtl/resv_pkg.sv
package resv_pkg;

  // Why the reservation is dropped in a given cycle (observation aid).
  typedef enum logic [2:0] {
    CLR_NONE    = 3'd0,
    CLR_EXC     = 3'd1,
    CLR_SNOOP   = 3'd2,
    CLR_SC_DONE = 3'd3,
    CLR_LL_LOST = 3'd4
  } clr_cause_e;

  // Number of offset bits for a block of the given byte size.
  function automatic int unsigned ofs_bits(input int unsigned blk_bytes);
    return (blk_bytes <= 1) ? 0 : $clog2(blk_bytes);
  endfunction

endpackage

// File: rtl/resv_blk_cmp.sv
module resv_blk_cmp #(
  parameter int AW    = 32,
  parameter int OFS_W = 4
) (
  input  logic          en,
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  output logic          hit
);
  localparam logic [AW-1:0] LOW_ONES = AW'((64'd1 << OFS_W) - 64'd1);
  localparam logic [AW-1:0] BLK_MASK = ~LOW_ONES;

  function automatic logic [AW-1:0] blk_base(input logic [AW-1:0] a);
    return a & BLK_MASK;
  endfunction

  assign hit = en && (blk_base(addr_a) == blk_base(addr_b));

endmodule

// File: rtl/resv_link_reg.sv
module resv_link_reg #(
  parameter int AW    = 32,
  parameter int OFS_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          load_ok,
  input  logic          clr,
  input  logic [AW-1:0] load_addr,
  output logic          valid,
  output logic [AW-1:0] link_addr
);
  localparam logic [AW-1:0] LOW_ONES = AW'((64'd1 << OFS_W) - 64'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid     <= 1'b0;
      link_addr <= '0;
    end else if (load) begin
      valid     <= load_ok;
      link_addr <= load_addr & ~LOW_ONES;
    end else if (clr) begin
      valid     <= 1'b0;
    end
  end

endmodule

// File: rtl/resv_judge.sv
module resv_judge
  import resv_pkg::*;
(
  input  logic       req_valid,
  input  logic       req_sc,
  input  logic       exc_event,
  input  logic       link_valid,
  input  logic       req_hit_link,
  input  logic       snoop_hit_link,
  input  logic       snoop_hit_req,
  output logic       sc_req,
  output logic       ll_req,
  output logic       sc_ok,
  output logic       ll_ok,
  output logic       clr,
  output clr_cause_e cause
);
  assign sc_req = req_valid && req_sc;
  assign ll_req = req_valid && !req_sc;

  // Exceptions and hitting snoops win over the request of the same cycle.
  assign sc_ok = sc_req && link_valid && req_hit_link && !exc_event && !snoop_hit_link;
  assign ll_ok = ll_req && !exc_event && !snoop_hit_req;

  always_comb begin
    cause = CLR_NONE;
    if (exc_event)                 cause = CLR_EXC;
    else if (snoop_hit_link)       cause = CLR_SNOOP;
    else if (sc_req)               cause = CLR_SC_DONE;
    else if (ll_req && !ll_ok)     cause = CLR_LL_LOST;
  end

  assign clr = (cause != CLR_NONE);

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int BLK_BYTES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_sc,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          snoop_valid,
  input  logic [AW-1:0] snoop_addr,
  input  logic          exc_event,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_result,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  localparam int OFS_W = ofs_bits(BLK_BYTES);

  function automatic logic [DW-1:0] result_word(input logic ok);
    return {{(DW-1){1'b0}}, ok};
  endfunction

  logic          link_valid;
  logic [AW-1:0] link_addr;
  logic          req_hit_link;
  logic          snoop_hit_link;
  logic          snoop_hit_req;
  logic          sc_req;
  logic          ll_req;
  logic          sc_ok;
  logic          ll_ok;
  logic          resv_clr;
  clr_cause_e    clr_cause;

  resv_blk_cmp #(.AW(AW), .OFS_W(OFS_W)) u_cmp_req (
    .en(req_valid), .addr_a(req_addr), .addr_b(link_addr), .hit(req_hit_link)
  );

  resv_blk_cmp #(.AW(AW), .OFS_W(OFS_W)) u_cmp_snoop (
    .en(snoop_valid && link_valid), .addr_a(snoop_addr), .addr_b(link_addr),
    .hit(snoop_hit_link)
  );

  resv_blk_cmp #(.AW(AW), .OFS_W(OFS_W)) u_cmp_new (
    .en(snoop_valid && req_valid), .addr_a(snoop_addr), .addr_b(req_addr),
    .hit(snoop_hit_req)
  );

  resv_judge u_judge (
    .req_valid(req_valid), .req_sc(req_sc), .exc_event(exc_event),
    .link_valid(link_valid), .req_hit_link(req_hit_link),
    .snoop_hit_link(snoop_hit_link), .snoop_hit_req(snoop_hit_req),
    .sc_req(sc_req), .ll_req(ll_req), .sc_ok(sc_ok), .ll_ok(ll_ok),
    .clr(resv_clr), .cause(clr_cause)
  );

  resv_link_reg #(.AW(AW), .OFS_W(OFS_W)) u_link (
    .clk(clk), .rst_n(rst_n), .load(ll_req), .load_ok(ll_ok), .clr(resv_clr),
    .load_addr(req_addr), .valid(link_valid), .link_addr(link_addr)
  );

  assign rsp_valid  = sc_req;
  assign rsp_result = result_word(sc_ok);
  assign mem_we     = sc_ok;
  assign mem_addr   = req_addr;
  assign mem_wdata  = req_wdata;

endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk
  import resv_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_sc,
  input logic          exc_event,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_result,
  input logic          mem_we,
  input logic          link_valid,
  input logic          snoop_hit_link,
  input logic          snoop_hit_req,
  input clr_cause_e    clr_cause
);
  a_r3_result_is_bit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_result <= DW'(1)));

  a_r3_no_rsp_without_sc: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_sc) |-> !rsp_valid);

  a_r4_write_needs_success: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (rsp_valid && rsp_result == DW'(1)));

  a_r4_fail_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_result == '0) |-> !mem_we);

  a_r2_success_needs_resv: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> link_valid);

  a_r5_exc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    exc_event |=> !link_valid);

  a_r5_exc_blocks_sc: assert property (@(posedge clk) disable iff (!rst_n)
    exc_event |-> !mem_we);

  a_r6_snoop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_hit_link && !(req_valid && !req_sc)) |=> !link_valid);

  a_r8_sc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sc) |=> !link_valid);

  a_r10_snoop_beats_sc: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_hit_link |-> !mem_we);

  a_r12_ll_lost: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_sc && snoop_hit_req) |=> !link_valid);

  a_r1_ll_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_sc && !exc_event && !snoop_hit_req) |=> link_valid);

  a_r5_cause_exc: assert property (@(posedge clk) disable iff (!rst_n)
    exc_event |-> (clr_cause == CLR_EXC));

endmodule

bind resv_monitor resv_monitor_chk #(.AW(AW), .DW(DW)) u_resv_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sc(req_sc),
  .exc_event(exc_event), .rsp_valid(rsp_valid), .rsp_result(rsp_result),
  .mem_we(mem_we), .link_valid(link_valid), .snoop_hit_link(snoop_hit_link),
  .snoop_hit_req(snoop_hit_req), .clr_cause(clr_cause)
);

// File: tb/test_resv_monitor.sv
`timescale 1ns/100ps
module test_resv_monitor;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_sc = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          snoop_valid = 1'b0;
  logic [AW-1:0] snoop_addr = '0;
  logic          exc_event = 1'b0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_result;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  resv_monitor #(.AW(AW), .DW(DW), .BLK_BYTES(16)) i_resv_monitor (.*);

  always #2 clk = ~clk;

  typedef struct {
    bit            ok;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // Bench-side reservation model, written from the requirements.
  bit            m_valid = 1'b0;
  logic [AW-1:0] m_blk   = '0;

  function automatic logic [AW-1:0] blk(input logic [AW-1:0] a);
    return a >> 4;
  endfunction

  task automatic drive(input bit sc, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit sv, input logic [AW-1:0] sa, input bit ex,
                       input string tag);
    exp_t e;
    bit   shit;
    @(posedge clk);
    #1;
    shit = sv && m_valid && (blk(sa) == m_blk);
    if (sc) begin
      e.ok   = m_valid && (blk(a) == m_blk) && !ex && !shit;
      e.addr = a;
      e.data = d;
      e.tag  = tag;
      exp_q.push_back(e);
      m_valid = 1'b0;
    end else begin
      m_valid = !ex && !(sv && blk(sa) == blk(a));
      m_blk   = blk(a);
    end
    req_valid = 1'b1; req_sc = sc; req_addr = a; req_wdata = d;
    snoop_valid = sv; snoop_addr = sa; exc_event = ex;
  endtask

  task automatic idle(input bit sv, input logic [AW-1:0] sa, input bit ex);
    @(posedge clk);
    #1;
    if (ex || (sv && m_valid && blk(sa) == m_blk)) m_valid = 1'b0;
    req_valid = 1'b0; req_sc = 1'b0; req_addr = '0; req_wdata = '0;
    snoop_valid = sv; snoop_addr = sa; exc_event = ex;
  endtask

  // Monitor: compares at the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_cmp++;
        if (!rsp_valid || rsp_result != DW'(e.ok) || mem_we != e.ok) begin
          n_bad++;
          $display("FAIL %s: rsp_valid=%0b result=%0d we=%0b expected valid=1 result=%0d we=%0b",
                   e.tag, rsp_valid, rsp_result, mem_we, e.ok, e.ok);
        end else if (e.ok && (mem_addr != e.addr || mem_wdata != e.data)) begin
          n_bad++;
          $display("FAIL R4: addr=%h data=%h expected addr=%h data=%h",
                   mem_addr, mem_wdata, e.addr, e.data);
        end
      end else begin
        n_cmp++;
        if (rsp_valid || mem_we) begin
          n_bad++;
          $display("FAIL R3/R4 idle: rsp_valid=%0b we=%0b expected 0 0", rsp_valid, mem_we);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state seen at the outputs
    n_cmp++;
    if (rsp_valid || mem_we) begin
      n_bad++;
      $display("FAIL R11: rsp_valid=%0b we=%0b expected 0 0", rsp_valid, mem_we);
    end
    rst_n = 1'b1;
    drive(1, 32'h100, 32'hA1, 0, 0, 0, "R11");            // no reservation after reset
    drive(0, 32'h100, 0, 0, 0, 0, "R1");
    drive(1, 32'h10C, 32'hB2, 0, 0, 0, "R1 R2");          // same block, other offset
    drive(1, 32'h100, 32'hB3, 0, 0, 0, "R8");             // second SC fails
    drive(0, 32'h200, 0, 0, 0, 0, "R2");
    drive(1, 32'h210, 32'hC4, 0, 0, 0, "R2");             // neighbouring block fails
    drive(0, 32'h300, 0, 0, 0, 0, "R5");
    idle(0, 0, 1);
    drive(1, 32'h300, 32'hD5, 0, 0, 0, "R5");             // exception in between
    drive(0, 32'h300, 0, 0, 0, 0, "R5");
    drive(1, 32'h300, 32'hD6, 0, 0, 1, "R5");             // exception with SC
    drive(0, 32'h400, 0, 0, 0, 1, "R5");                  // exception with LL
    drive(1, 32'h400, 32'hD7, 0, 0, 0, "R5");
    drive(0, 32'h500, 0, 0, 0, 0, "R6");
    idle(1, 32'h508, 0);
    drive(1, 32'h500, 32'hE8, 0, 0, 0, "R6");             // snoop hit cleared it
    drive(0, 32'h500, 0, 0, 0, 0, "R7");
    idle(1, 32'h600, 0);
    drive(1, 32'h504, 32'hE9, 0, 0, 0, "R7");             // unrelated snoop
    drive(0, 32'h700, 0, 0, 0, 0, "R9");
    drive(0, 32'h800, 0, 0, 0, 0, "R9");
    drive(1, 32'h700, 32'hF0, 0, 0, 0, "R9");             // old block replaced
    drive(0, 32'h700, 0, 0, 0, 0, "R9");
    drive(0, 32'h800, 0, 0, 0, 0, "R9");
    drive(1, 32'h808, 32'hF1, 0, 0, 0, "R9");             // newest block wins
    drive(0, 32'h900, 0, 0, 0, 0, "R10");
    drive(1, 32'h900, 32'hF2, 1, 32'h90C, 0, "R10");      // snoop with SC
    drive(0, 32'hA00, 0, 1, 32'hA04, 0, "R12");           // snoop with LL
    drive(1, 32'hA00, 32'hF3, 0, 0, 0, "R12");
    drive(0, 32'hB00, 0, 0, 0, 0, "R7");
    drive(1, 32'hB00, 32'hF4, 1, 32'hC00, 0, "R7");       // other-block snoop with SC
    for (int i = 0; i < 8; i++) begin
      drive(0, 32'h1000 + 32'(i) * 32'h40, 0, 0, 0, 0, "R1");
      drive(1, 32'h1000 + 32'(i) * 32'h40 + 32'(i), 32'(i), (i % 3) == 0,
            32'h1000 + 32'(i) * 32'h40 + 32'((i % 2) * 16), 0, "R2 R10");
    end
    idle(0, 0, 0);
    idle(0, 0, 0);
    @(negedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule